// File: doc/BRIEF.md
# Accelerator Reply Frame Generator

This block builds the reply frame that an accelerator sends back for each application request and streams it out one octet at a time. When it is told to start, it captures three values: the requester's MAC address (taken from the source field of the request), the station's own current MAC address, and the 16-bit result. It then produces a complete frame: a seven-octet preamble, a start delimiter, the Ethernet header, the result, zero padding and the frame check sequence. The frame is never stored. Each octet is selected from the captured fields at the moment it is due, and the checksum is accumulated as the octets go out. This lets transmission begin as soon as the request's last operand byte has arrived.

The octet rate matches an output serializer that takes one octet every `CYC_PER_OCTET` clock cycles. Each octet is marked by a one-cycle valid strobe, and the final octet also carries a done strobe. Replies never carry a VLAN tag. An optional output register can be clocked on the falling clock edge to shift output timing by half a period. The edge is chosen by a phase-select pin that is sampled only while reset is held.

Top module: `reply_frame_gen`

## Requirements
- R1: During and right after a synchronous reset, `tx_valid` and `tx_done` are 0, `tx_octet` is 0x00 and no octets are produced until a start is accepted.
- R2: A `start` seen by a rising edge while idle captures `req_mac`, `stn_mac` and `result`. Later changes on those inputs do not alter the frame being sent.
- R3: A frame is exactly 72 octets, sent in index order starting at 0. Octets 0 to 6 are 0x55 and octet 7 is 0xD5.
- R4: Octets 8 to 13 carry the captured requester MAC and octets 14 to 19 carry the captured station MAC, each sent with bits 47:40 first.
- R5: Octets 20 and 21 are 0x88 and 0xB5. No VLAN tag is ever inserted.
- R6: Octets 22 and 23 carry the result, high byte first, and octets 24 to 67 are all 0x00.
- R7: Octets 68 to 71 are the FCS, sent low byte first. The FCS is the inverted result of a reflected CRC-32 (polynomial 0x04C11DB7, preset to all ones) over octets 8 to 67. A CRC over octets 8 to 71 therefore leaves the residue 0xDEBB20E3.
- R8: `tx_valid` is a one-cycle pulse, and successive octets of a frame are exactly `CYC_PER_OCTET` cycles apart (default 4).
- R9: `tx_done` pulses exactly once per frame, together with octet 71, and never without `tx_valid`.
- R10: A `start` that arrives while a frame is in progress is ignored. No second frame follows and the current frame is unchanged.
- R11: `phase_sel` is sampled only during reset. With 0, the output register updates on the rising edge and octet 0 appears one cycle after the accepting edge. With 1, it updates on the falling edge and octet 0 appears half a cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples `phase_sel` |
| phase_sel | input | 1 | Output edge select sampled in reset: 0 rising, 1 falling |
| start | input | 1 | Start pulse for one reply frame |
| req_mac | input | 48 | Source MAC of the request, used as reply destination |
| stn_mac | input | 48 | Current station MAC, used as reply source |
| result | input | 16 | Accelerator result placed in the payload |
| tx_octet | output | 8 | Current frame octet (0x00 between strobes) |
| tx_valid | output | 1 | One-cycle strobe marking a new octet |
| tx_done | output | 1 | Strobe on the final octet of the frame |

## Verification
The results are swept through a walking one across all 16 bit positions plus all-zeros and all-ones. Each sweep step also changes the requester and station addresses. This separates a swapped result byte order or a stuck result bit from a header fault, and each changed payload bit must move the FCS. Every frame is checked field by field against a CRC computed independently in the bench, and against the fixed residue over the whole checked span. One frame gets a second start mid-frame, with all three data inputs altered at the same time. This separates a design that ignores the pulse from one that restarts or picks up the new values. Frames sent under both phase settings, including a `phase_sel` change after reset, separate rising-edge from falling-edge output timing through the half-cycle difference in the first octet's arrival.

// File: rtl/rfg_pkg.sv
package rfg_pkg;

    // frame layout, in octet positions counted from the first preamble octet
    localparam int PREAMBLE_LEN = 7;
    localparam int MAC_OCTETS   = 6;
    localparam int PAD_OCTETS   = 44;
    localparam int FCS_OCTETS   = 4;
    localparam int DST_POS      = PREAMBLE_LEN + 1;
    localparam int SRC_POS      = DST_POS + MAC_OCTETS;
    localparam int TYPE_POS     = SRC_POS + MAC_OCTETS;
    localparam int RES_POS      = TYPE_POS + 2;
    localparam int PAD_POS      = RES_POS + 2;
    localparam int FCS_POS      = PAD_POS + PAD_OCTETS;
    localparam int FRAME_OCTETS = FCS_POS + FCS_OCTETS;
    localparam int IDX_W        = $clog2(FRAME_OCTETS);

    localparam logic [7:0]  PREAMBLE_OCTET = 8'h55;
    localparam logic [7:0]  SFD_OCTET      = 8'hD5;
    localparam logic [15:0] REPLY_ETYPE    = 16'h88B5;
    localparam logic [31:0] CRC_PRESET     = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL  = 32'hEDB8_8320;

    typedef logic [IDX_W-1:0] octet_idx_t;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_SEND
    } seq_state_e;

    // values captured when a start is accepted
    typedef struct packed {
        logic [47:0] dst;
        logic [47:0] src;
        logic [15:0] res;
    } reply_fields_t;

    // one output beat towards the serializer
    typedef struct packed {
        logic [7:0] data;
        logic       valid;
        logic       last;
    } tx_beat_t;

    // octet k of a MAC address, k = 0 being bits 47:40
    function automatic logic [7:0] mac_octet(input logic [47:0] mac, input int k);
        return 8'(mac >> (8 * (MAC_OCTETS - 1 - k)));
    endfunction

    // reflected CRC-32 advanced by one octet, low bit first
    function automatic logic [31:0] crc_next(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rfg_seq.sv
module rfg_seq
    import rfg_pkg::*;
#(
    parameter int CYC_PER_OCTET = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       accept,
    output logic       busy,
    output logic       strobe,
    output logic       last,
    output octet_idx_t idx
);

    localparam int TICK_W = (CYC_PER_OCTET > 1) ? $clog2(CYC_PER_OCTET) : 1;
    localparam logic [TICK_W-1:0] TICK_MAX = TICK_W'(CYC_PER_OCTET - 1);
    localparam octet_idx_t LAST_IDX = octet_idx_t'(FRAME_OCTETS - 1);

    seq_state_e        state_q;
    logic [TICK_W-1:0] tick_q;
    octet_idx_t        idx_q;
    logic              tick_wrap;

    assign busy      = (state_q == SEQ_SEND);
    assign accept    = (state_q == SEQ_IDLE) && start;
    assign strobe    = busy && (tick_q == '0);
    assign tick_wrap = (tick_q == TICK_MAX);
    assign last      = strobe && (idx_q == LAST_IDX);
    assign idx       = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            tick_q  <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_SEND;
                        tick_q  <= '0;
                        idx_q   <= '0;
                    end
                end
                SEQ_SEND: begin
                    if (tick_wrap) begin
                        tick_q <= '0;
                        if (idx_q == LAST_IDX) begin
                            state_q <= SEQ_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rfg_octet_mux.sv
module rfg_octet_mux
    import rfg_pkg::*;
(
    input  octet_idx_t    idx,
    input  reply_fields_t fields,
    input  logic [31:0]   crc,
    output logic [7:0]    octet
);

    int          pos;
    logic [31:0] fcs_word;

    assign fcs_word = ~crc;

    always_comb begin
        pos   = int'(idx);
        octet = 8'h00;
        if (pos < PREAMBLE_LEN) begin
            octet = PREAMBLE_OCTET;
        end else if (pos == PREAMBLE_LEN) begin
            octet = SFD_OCTET;
        end else if (pos < SRC_POS) begin
            octet = mac_octet(fields.dst, pos - DST_POS);
        end else if (pos < TYPE_POS) begin
            octet = mac_octet(fields.src, pos - SRC_POS);
        end else if (pos == TYPE_POS) begin
            octet = REPLY_ETYPE[15:8];
        end else if (pos == TYPE_POS + 1) begin
            octet = REPLY_ETYPE[7:0];
        end else if (pos == RES_POS) begin
            octet = fields.res[15:8];
        end else if (pos == RES_POS + 1) begin
            octet = fields.res[7:0];
        end else if (pos < FCS_POS) begin
            octet = 8'h00;
        end else if (pos < FRAME_OCTETS) begin
            octet = 8'(fcs_word >> (8 * (pos - FCS_POS)));
        end
    end

endmodule

// File: rtl/rfg_fcs_acc.sv
module rfg_fcs_acc
    import rfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        enable,
    input  logic [7:0]  octet,
    output logic [31:0] crc
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= CRC_PRESET;
        end else if (enable) begin
            crc_q <= crc_next(crc_q, octet);
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/rfg_phase_out.sv
module rfg_phase_out
    import rfg_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     phase_sel,
    input  tx_beat_t beat_in,
    output tx_beat_t beat_out,
    output logic     phase_q
);

    generate
        if (OUT_REG) begin : g_reg
            logic     ph_q;
            tx_beat_t rise_q;
            tx_beat_t fall_q;

            // edge choice is taken only while reset is held
            always_ff @(posedge clk) begin
                if (rst) begin
                    ph_q <= phase_sel;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    rise_q <= '0;
                end else begin
                    rise_q <= beat_in;
                end
            end

            always_ff @(negedge clk) begin
                if (rst) begin
                    fall_q <= '0;
                end else begin
                    fall_q <= beat_in;
                end
            end

            assign beat_out = ph_q ? fall_q : rise_q;
            assign phase_q  = ph_q;
        end else begin : g_pass
            assign beat_out = beat_in;
            assign phase_q  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/reply_frame_gen.sv
module reply_frame_gen
    import rfg_pkg::*;
#(
    parameter int CYC_PER_OCTET = 4,
    parameter bit OUT_REG       = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        phase_sel,
    input  logic        start,
    input  logic [47:0] req_mac,
    input  logic [47:0] stn_mac,
    input  logic [15:0] result,
    output logic [7:0]  tx_octet,
    output logic        tx_valid,
    output logic        tx_done
);

    reply_fields_t fields_q;
    logic          accept;
    logic          busy;
    logic          strobe;
    logic          last;
    octet_idx_t    idx;
    logic [7:0]    octet;
    logic [31:0]   crc;
    logic          crc_en;
    tx_beat_t      beat_core;
    tx_beat_t      beat_out;
    logic          phase_q;

    rfg_seq #(
        .CYC_PER_OCTET(CYC_PER_OCTET)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .accept(accept),
        .busy  (busy),
        .strobe(strobe),
        .last  (last),
        .idx   (idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q <= '0;
        end else if (accept) begin
            fields_q <= '{dst: req_mac, src: stn_mac, res: result};
        end
    end

    rfg_octet_mux u_mux (
        .idx   (idx),
        .fields(fields_q),
        .crc   (crc),
        .octet (octet)
    );

    assign crc_en = strobe && (int'(idx) >= DST_POS) && (int'(idx) < FCS_POS);

    rfg_fcs_acc u_fcs (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .enable(crc_en),
        .octet (octet),
        .crc   (crc)
    );

    assign beat_core = '{data: (strobe ? octet : 8'h00), valid: strobe, last: last};

    rfg_phase_out #(
        .OUT_REG(OUT_REG)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .phase_sel(phase_sel),
        .beat_in  (beat_core),
        .beat_out (beat_out),
        .phase_q  (phase_q)
    );

    assign tx_octet = beat_out.data;
    assign tx_valid = beat_out.valid;
    assign tx_done  = beat_out.last;

endmodule

// File: rtl/rfg_checker.sv
module rfg_checker
    import rfg_pkg::*;
#(
    parameter int CYC_PER_OCTET = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        strobe,
    input octet_idx_t  idx,
    input logic [15:0] lat_res,
    input logic [47:0] lat_dst,
    input logic        phase_q
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !busy) else $error("reset did not leave sequencer idle"); // R1

    AST_FIRST_OCTET: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (strobe && idx == '0)) else $error("frame did not open with octet 0"); // R2

    AST_BUSY_START_RES: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(lat_res)) else $error("result recaptured mid-frame"); // R10

    AST_BUSY_START_DST: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(lat_dst)) else $error("destination recaptured mid-frame"); // R10

    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
        (CYC_PER_OCTET > 1 && strobe) |=> !strobe) else $error("octet strobes too close"); // R8

    AST_PHASE_HELD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(phase_q)) else $error("edge choice moved outside reset"); // R11

endmodule

bind reply_frame_gen rfg_checker #(
    .CYC_PER_OCTET(CYC_PER_OCTET)
) u_rfg_checker (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .strobe (strobe),
    .idx    (idx),
    .lat_res(fields_q.res),
    .lat_dst(fields_q.dst),
    .phase_q(phase_q)
);

// File: tb/reply_frame_gen_test.sv
`timescale 1ns/1ps
module reply_frame_gen_test;

    localparam int CPB    = 4;
    localparam int NFRAME = 72;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phase_sel = 1'b0;
    logic        start = 1'b0;
    logic [47:0] req_mac = '0;
    logic [47:0] stn_mac = '0;
    logic [15:0] result = '0;
    logic [7:0]  tx_octet;
    logic        tx_valid;
    logic        tx_done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // monitor state
    logic [7:0] cap [0:79];
    int cap_n = 0;
    int first_cyc = 0;
    int prev_cyc = 0;
    int gap_err = 0;
    int done_cnt = 0;
    int done_pos = -1;
    int valid_total = 0;
    int start_cyc = 0;

    reply_frame_gen #(.CYC_PER_OCTET(CPB), .OUT_REG(1'b1)) uut (
        .clk(clk), .rst(rst), .phase_sel(phase_sel), .start(start),
        .req_mac(req_mac), .stn_mac(stn_mac), .result(result),
        .tx_octet(tx_octet), .tx_valid(tx_valid), .tx_done(tx_done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // sample 5 ns before each rising edge: stable for both output edges
    always begin
        @(posedge clk);
        #15;
        if (tx_valid) begin
            if (cap_n < 80) cap[cap_n] = tx_octet;
            if (cap_n == 0) first_cyc = cyc;
            else if (cyc - prev_cyc != CPB) gap_err++;
            prev_cyc = cyc;
            if (tx_done) begin
                done_cnt++;
                done_pos = cap_n;
            end
            cap_n++;
            valid_total++;
        end else if (tx_done) begin
            done_cnt++;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [63:0] pack_be(input int lo, input int n);
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) r = (r << 8) | 64'(cap[lo + i]);
        return r;
    endfunction

    // bit-serial reflected CRC-32 over captured octets lo..hi
    function automatic logic [31:0] crc_span(input int lo, input int hi);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = lo; i <= hi; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ cap[i][b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return c;
    endfunction

    task automatic do_reset(input logic ph);
        @(posedge clk); #5;
        rst = 1'b1;
        phase_sel = ph;
        start = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        rst = 1'b0;
        @(posedge clk); #15;
        chk("R1", "tx_valid after reset", 64'(tx_valid), 64'd0);
        chk("R1", "tx_done after reset", 64'(tx_done), 64'd0);
        chk("R1", "tx_octet after reset", 64'(tx_octet), 64'd0);
        cap_n = 0; valid_total = 0;
        repeat (10) @(posedge clk);
        #15;
        chk("R1", "no octets while idle", 64'(valid_total), 64'd0);
    endtask

    task automatic launch(input logic [47:0] d, input logic [47:0] s, input logic [15:0] r);
        @(posedge clk); #5;
        req_mac = d; stn_mac = s; result = r;
        cap_n = 0; gap_err = 0; done_cnt = 0; done_pos = -1; first_cyc = -1;
        start = 1'b1;
        @(posedge clk); #1;
        start_cyc = cyc;
        #4;
        start = 1'b0;
    endtask

    task automatic wait_frame();
        for (int k = 0; k < 4000 && done_cnt == 0; k++) @(posedge clk);
        if (done_cnt == 0) chk("R9", "frame completion (watchdog)", 64'd0, 64'd1);
        repeat (CPB + 2) @(posedge clk);
    endtask

    task automatic verify(input logic [47:0] d, input logic [47:0] s,
                          input logic [15:0] r, input logic neg);
        int nz;
        logic [31:0] exp_fcs;
        chk("R3", "octet count", 64'(cap_n), 64'(NFRAME));
        chk("R3", "preamble and SFD", pack_be(0, 8), 64'h5555_5555_5555_55D5);
        chk("R4", "destination = requester", pack_be(8, 6), 64'(d));
        chk("R4", "source = station", pack_be(14, 6), 64'(s));
        chk("R5", "ethertype untagged", pack_be(20, 2), 64'h88B5);
        chk("R6", "result high first", pack_be(22, 2), 64'(r));
        nz = 0;
        for (int i = 24; i < 68; i++) if (cap[i] != 8'h00) nz++;
        chk("R6", "padding zero", 64'(nz), 64'd0);
        exp_fcs = ~crc_span(8, 67);
        chk("R7", "FCS low byte first", {32'h0, cap[71], cap[70], cap[69], cap[68]}, 64'(exp_fcs));
        chk("R7", "CRC residue", 64'(crc_span(8, 71)), 64'hDEBB_20E3);
        chk("R8", "octet spacing errors", 64'(gap_err), 64'd0);
        chk("R9", "done count", 64'(done_cnt), 64'd1);
        chk("R9", "done on last octet", 64'(done_pos), 64'(NFRAME - 1));
        chk("R11", "first octet delay", 64'(first_cyc - start_cyc), neg ? 64'd0 : 64'd1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [47:0] d, s;
        logic [15:0] r;
        int vt;

        // rising-edge output, result sweep
        do_reset(1'b0);
        for (int k = 0; k < 18; k++) begin
            r = (k == 16) ? 16'h0000 : (k == 17) ? 16'hFFFF : 16'(1 << k);
            d = {16'h0A00 + 16'(k), 32'hC0DE_0000 + 32'(k * 7)};
            s = {24'h02_1122, 8'(k), 16'hBEEF};
            launch(d, s, r);
            wait_frame();
            verify(d, s, r, 1'b0);
        end

        // second start mid-frame with altered inputs
        d = 48'h0013_3700_AB01; s = 48'h0090_CF00_BEEF; r = 16'h3F80;
        vt = valid_total;
        launch(d, s, r);
        repeat (40) @(posedge clk);
        #5;
        req_mac = 48'hFFFF_0000_FFFF; stn_mac = 48'h1234_5678_9ABC; result = 16'h5A5A;
        start = 1'b1;
        @(posedge clk); #5;
        start = 1'b0;
        wait_frame();
        verify(d, s, r, 1'b0);
        chk("R2", "captured result kept", pack_be(22, 2), 64'(r));
        repeat (400) @(posedge clk);
        #15;
        chk("R10", "no frame from ignored start", 64'(valid_total - vt), 64'(NFRAME));

        // falling-edge output; pin changes after reset must not matter
        do_reset(1'b1);
        @(posedge clk); #5;
        phase_sel = 1'b0;
        for (int k = 0; k < 3; k++) begin
            r = 16'hA5C3 ^ 16'(k * 16'h1111);
            d = {32'h0200_0000, 16'(k)};
            s = {16'h0090, 32'hCF00_BE00 + 32'(k)};
            launch(d, s, r);
            wait_frame();
            verify(d, s, r, 1'b1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule